// File: doc/BRIEF.md
# Serial DAC Host Write Controller

This block is the host side of a three-wire serial link to a 12-bit voltage-output converter. It runs on the system clock. A request carries a 12-bit output code and a 2-bit power mode. The block packs these into a 16-bit word and drives the frame-select line (`sync_n`), the serial clock (`sclk`) and the data line (`din`). The idle level of `sclk` is low. Data changes on each rising edge, so it is stable at every falling edge, where the converter samples it.

The `sclk` half-period and the minimum high time of the frame select are counted in system clocks. By default both are rounded up from the converter's nanosecond limits for the chosen system clock. Before every frame the controller ensures that the frame select has been high for the minimum time.

A build-time option splits the frame into two 8-clock bursts and keeps `sync_n` low between them. A second option models a byte engine that shifts least significant bit first. The word is stored with each byte reversed, so the bits on the wire still arrive most significant first. A third option leaves `sync_n` low after a frame to save power. In that case the controller raises it for the minimum time just before the next frame.

Top module: `dacwr_host`

## Requirements
- R1: While reset is asserted, and until the first request after it, `sync_n` is 1, `sclk` is 0, `din` is 0, `busy` is 0 and `done` is 0.
- R2: The 16 bits sampled at the `sclk` falling edges of one frame, first bit as bit 15, equal {2'b00, mode[1:0], code[11:0]}: the power mode sits in bits 13:12 and the code in bits 11:0.
- R3: While `sync_n` stays low, `din` changes only in the same cycle as a rising edge of `sclk`.
- R4: Within a burst, every high phase of `sclk` lasts exactly HALF_CYC system clocks. The low phase from the fall of `sync_n` to the first rising edge also lasts HALF_CYC. Every low phase between two bits of the same burst also lasts HALF_CYC.
- R5: Every falling edge of `sync_n` is preceded by at least SYNC_HI_CYC consecutive cycles with `sync_n` high.
- R6: Each frame has exactly 16 `sclk` falling edges while `sync_n` is low. `sclk` toggles only while `sync_n` is low, and `sync_n` changes only while `sclk` is low.
- R7: With BYTE_MODE=1, `sclk` stays low for 2*HALF_CYC+BYTE_GAP_CYC cycles between the 8th falling edge and the 9th rising edge, and `sync_n` stays low across that gap.
- R8: At the end of a frame, `sync_n` returns high when IDLE_LOW=0. It remains low until the next request when IDLE_LOW=1.
- R9: When `req_valid` is seen while idle, `busy` is 1 in the next cycle. `done` is a single-cycle pulse at the end of the frame, with `busy` already 0 in that cycle. A request presented while `busy` is 1 is ignored: no extra frame is sent and the frame in flight keeps its original content.
- R10: With MIRROR=1, the word on the wire is the same as with MIRROR=0 for the same request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Write request, taken when idle |
| req_code | input | 12 | Output code for the converter |
| req_mode | input | 2 | Power mode field: 00 active, 01/10/11 power-down variants |
| busy | output | 1 | A frame is in progress |
| done | output | 1 | One-cycle pulse when a frame ends |
| sclk | output | 1 | Serial clock, idle low |
| sync_n | output | 1 | Active-low frame select |
| din | output | 1 | Serial data, changed on the rising edge of `sclk` |

## Verification
The bench builds two instances side by side and sends the same requests to both. The first uses HALF_CYC=2 and SYNC_HI_CYC=3, with a single 16-clock burst, most-significant-first storage and the frame select released at the end of each frame. The second uses HALF_CYC=3, SYNC_HI_CYC=5, BYTE_GAP_CYC=2, split bytes, mirrored storage and idle-low frame select. This pairing brings the byte gap, the mirror index path and the forced pre-frame high pulse into reach together with the plain path. Every power mode is combined with zero, full-scale, alternating and walking-one codes, so each bit position of the word is checked on the wire in both variants.

// File: rtl/dacwr_pkg.sv
package dacwr_pkg;

    localparam int CODE_W  = 12;
    localparam int MODE_W  = 2;
    localparam int FRAME_W = 16;
    localparam int BYTE_W  = 8;

    // converter limits in picoseconds
    localparam int T_SCLK_PERIOD_PS = 33000;
    localparam int T_SCLK_PHASE_PS  = 13000;
    localparam int T_SYNC_HIGH_PS   = 33000;

    typedef enum logic [1:0] {
        PM_ACTIVE   = 2'b00,
        PM_PD_LOW_R = 2'b01,
        PM_PD_MID_R = 2'b10,
        PM_PD_OPEN  = 2'b11
    } pmode_e;

    typedef struct packed {
        logic [1:0]        pad;
        pmode_e            mode;
        logic [CODE_W-1:0] code;
    } frame_t;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_GAP,
        ST_SHIFT,
        ST_BGAP
    } wr_state_e;

    function automatic int cycles_ceil(int ps, int clk_ps);
        return (ps + clk_ps - 1) / clk_ps;
    endfunction

    function automatic int half_cycles(int clk_ps);
        int a;
        int b;
        a = cycles_ceil(T_SCLK_PHASE_PS, clk_ps);
        b = cycles_ceil((T_SCLK_PERIOD_PS + 1) / 2, clk_ps);
        return (a > b) ? a : b;
    endfunction

    function automatic logic [BYTE_W-1:0] rev_byte(logic [BYTE_W-1:0] b);
        logic [BYTE_W-1:0] r;
        for (int i = 0; i < BYTE_W; i++) r[i] = b[BYTE_W-1-i];
        return r;
    endfunction

endpackage

// File: rtl/dacwr_frame.sv
module dacwr_frame
    import dacwr_pkg::*;
#(
    parameter bit MIRROR = 1'b0
) (
    input  logic [CODE_W-1:0]  code,
    input  logic [MODE_W-1:0]  mode,
    output logic [FRAME_W-1:0] word
);
    frame_t f;

    always_comb begin
        f.pad  = 2'b00;
        f.mode = pmode_e'(mode);
        f.code = code;
    end

    generate
        if (MIRROR) begin : g_mirror
            // each byte stored reversed for an LSB-first byte shifter
            assign word = {rev_byte(f[FRAME_W-1:BYTE_W]), rev_byte(f[BYTE_W-1:0])};
        end else begin : g_plain
            assign word = f;
        end
    endgenerate
endmodule

// File: rtl/dacwr_serializer.sv
module dacwr_serializer
    import dacwr_pkg::*;
#(
    parameter bit MIRROR = 1'b0
) (
    input  logic [FRAME_W-1:0] word,
    input  logic [3:0]         idx,
    output logic               bit_out
);
    generate
        if (MIRROR) begin : g_lsb_first
            // high byte first, each byte shifted from its stored LSB
            assign bit_out = word[{~idx[3], idx[2:0]}];
        end else begin : g_msb_first
            assign bit_out = word[4'd15 - idx];
        end
    endgenerate
endmodule

// File: rtl/dacwr_halftick.sv
module dacwr_halftick #(
    parameter int HALF_CYC = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic last
);
    localparam int CW = (HALF_CYC > 1) ? $clog2(HALF_CYC) : 1;
    localparam logic [CW-1:0] LAST_V = CW'(HALF_CYC - 1);

    logic [CW-1:0] cnt;

    assign last = run && (cnt == LAST_V);

    always_ff @(posedge clk) begin
        if (rst || !run || last) cnt <= '0;
        else                     cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/dacwr_host.sv
module dacwr_host
    import dacwr_pkg::*;
#(
    parameter int SYS_CLK_PS   = 10000,
    parameter int HALF_CYC     = half_cycles(SYS_CLK_PS),
    parameter int SYNC_HI_CYC  = cycles_ceil(T_SYNC_HIGH_PS, SYS_CLK_PS),
    parameter bit BYTE_MODE    = 1'b0,
    parameter int BYTE_GAP_CYC = 2,
    parameter bit MIRROR       = 1'b0,
    parameter bit IDLE_LOW     = 1'b0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [CODE_W-1:0] req_code,
    input  logic [MODE_W-1:0] req_mode,
    output logic              busy,
    output logic              done,
    output logic              sclk,
    output logic              sync_n,
    output logic              din
);
    localparam int HCW = $clog2(SYNC_HI_CYC + 1);
    localparam logic [HCW-1:0] HI_MAX  = HCW'(SYNC_HI_CYC);
    localparam logic [HCW-1:0] HI_NEED = HCW'(SYNC_HI_CYC - 1);
    localparam int GCW = (BYTE_GAP_CYC > 1) ? $clog2(BYTE_GAP_CYC) : 1;
    localparam logic [GCW-1:0] GAP_LAST = GCW'(BYTE_GAP_CYC - 1);
    localparam logic [4:0] BITS_ALL  = 5'(FRAME_W);
    localparam logic [4:0] BITS_BYTE = 5'(BYTE_W);

    wr_state_e            state;
    logic [FRAME_W-1:0]   word_q;
    logic [FRAME_W-1:0]   word_d;
    logic [4:0]           nbits;
    logic                 second;
    logic [HCW-1:0]       hi_cnt;
    logic [GCW-1:0]       gap_cnt;
    logic                 tick;
    logic                 next_bit;
    logic                 burst_end;

    dacwr_frame #(.MIRROR(MIRROR)) u_frame (
        .code (req_code),
        .mode (req_mode),
        .word (word_d)
    );

    dacwr_serializer #(.MIRROR(MIRROR)) u_ser (
        .word    (word_q),
        .idx     (nbits[3:0]),
        .bit_out (next_bit)
    );

    dacwr_halftick #(.HALF_CYC(HALF_CYC)) u_tick (
        .clk  (clk),
        .rst  (rst),
        .run  (state == ST_SHIFT),
        .last (tick)
    );

    assign burst_end = (nbits == BITS_ALL) ||
                       (BYTE_MODE && (nbits == BITS_BYTE) && !second);

    // consecutive cycles the frame select has been high
    always_ff @(posedge clk) begin
        if (rst || !sync_n)      hi_cnt <= '0;
        else if (hi_cnt != HI_MAX) hi_cnt <= hi_cnt + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_IDLE;
            word_q  <= '0;
            nbits   <= '0;
            second  <= 1'b0;
            gap_cnt <= '0;
            busy    <= 1'b0;
            done    <= 1'b0;
            sclk    <= 1'b0;
            sync_n  <= 1'b1;
            din     <= 1'b0;
        end else begin
            done <= 1'b0;
            unique case (state)
                ST_IDLE: begin
                    if (req_valid) begin
                        word_q <= word_d;
                        busy   <= 1'b1;
                        sync_n <= 1'b1;
                        state  <= ST_GAP;
                    end
                end
                ST_GAP: begin
                    if (sync_n && (hi_cnt >= HI_NEED)) begin
                        sync_n <= 1'b0;
                        nbits  <= '0;
                        second <= 1'b0;
                        state  <= ST_SHIFT;
                    end
                end
                ST_SHIFT: begin
                    if (tick) begin
                        if (sclk) begin
                            sclk  <= 1'b0;
                            nbits <= nbits + 1'b1;
                        end else if (!burst_end) begin
                            sclk <= 1'b1;
                            din  <= next_bit;
                        end else if (nbits == BITS_ALL) begin
                            state  <= ST_IDLE;
                            busy   <= 1'b0;
                            done   <= 1'b1;
                            sync_n <= IDLE_LOW ? 1'b0 : 1'b1;
                        end else begin
                            second  <= 1'b1;
                            gap_cnt <= '0;
                            state   <= ST_BGAP;
                        end
                    end
                end
                ST_BGAP: begin
                    if (gap_cnt == GAP_LAST) state <= ST_SHIFT;
                    else                     gap_cnt <= gap_cnt + 1'b1;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/dacwr_host_chk.sv
module dacwr_host_chk #(
    parameter int HALF_CYC    = 2,
    parameter int SYNC_HI_CYC = 4,
    parameter bit IDLE_LOW    = 1'b0
) (
    input logic clk,
    input logic rst,
    input logic busy,
    input logic done,
    input logic sclk,
    input logic sync_n,
    input logic din
);
    int   hi_run;
    int   sclk_run;
    logic sclk_prev;

    always_ff @(posedge clk) begin
        if (rst) begin
            hi_run    <= 0;
            sclk_run  <= 0;
            sclk_prev <= 1'b0;
        end else begin
            sclk_prev <= sclk;
            if (!sync_n)               hi_run <= 0;
            else if (hi_run < 1000000) hi_run <= hi_run + 1;
            if (sclk != sclk_prev)       sclk_run <= 1;
            else if (sclk_run < 1000000) sclk_run <= sclk_run + 1;
        end
    end

    a_r1_reset_idle: assert property (@(posedge clk)
        rst |=> (sync_n && !sclk && !busy && !done));

    a_r3_din_on_rise: assert property (@(posedge clk) disable iff (rst)
        (!sync_n && !$past(sync_n) && (din != $past(din))) |-> (sclk && !$past(sclk)));

    a_r4_high_width: assert property (@(posedge clk) disable iff (rst)
        $fell(sclk) |-> (sclk_run == HALF_CYC));

    a_r5_sync_gap: assert property (@(posedge clk) disable iff (rst)
        $fell(sync_n) |-> (hi_run >= SYNC_HI_CYC));

    a_r6_sync_sclk_low: assert property (@(posedge clk) disable iff (rst)
        !$stable(sync_n) |-> (!sclk && !$past(sclk)));

    a_r6_sclk_in_frame: assert property (@(posedge clk) disable iff (rst)
        !$stable(sclk) |-> (!sync_n && !$past(sync_n)));

    a_r8_end_level: assert property (@(posedge clk) disable iff (rst)
        done |-> (sync_n == !IDLE_LOW));

    a_r9_done_pulse: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    a_r9_done_idle: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);

    a_r9_busy_end: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> done);
endmodule

bind dacwr_host dacwr_host_chk #(
    .HALF_CYC    (HALF_CYC),
    .SYNC_HI_CYC (SYNC_HI_CYC),
    .IDLE_LOW    (IDLE_LOW)
) u_chk (
    .clk    (clk),
    .rst    (rst),
    .busy   (busy),
    .done   (done),
    .sclk   (sclk),
    .sync_n (sync_n),
    .din    (din)
);

// File: tb/sim_dacwr_host.sv
module sim_dacwr_mon #(
    parameter int HALF  = 2,
    parameter int SHI   = 3,
    parameter bit BYTES = 1'b0,
    parameter int GAP   = 2
) (
    input logic clk,
    input logic rst,
    input logic sclk,
    input logic sync_n,
    input logic din,
    input logic busy,
    input logic done
);
    int          checks = 0;
    int          fails = 0;
    int          frames = 0;
    logic [15:0] sh = '0;
    logic [15:0] last_word = '0;
    int          nfall = 16;
    int          last_nfall = 0;
    int          hi_run = 0;
    int          run = 0;
    logic        p_sclk = 1'b0;
    logic        p_sync = 1'b1;
    logic        p_din = 1'b0;
    logic        p_done = 1'b0;

    task automatic chk(input bit ok, input string tag, input int act, input int expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s in %m: actual=%0d expected=%0d", tag, act, expv);
        end
    endtask

    always @(negedge clk) begin
        if (rst) begin
            hi_run = 0;
            run    = 0;
            nfall  = 16;
        end else begin
            if (!sync_n && p_sync) chk(hi_run >= SHI, "R5 sync high time", hi_run, SHI);
            if (sync_n && !p_sync) chk(nfall == 16, "R6/R7 falls before sync release", nfall, 16);
            if (sync_n && (sclk != p_sclk)) chk(0, "R6 sclk toggled outside frame", sclk, p_sclk);
            if (!sync_n && !p_sync == 1'b0 && 1'b0) chk(1, "", 0, 0);
            if (!sync_n && !p_sync && (din !== p_din) && !(sclk && !p_sclk))
                chk(0, "R3 din moved away from rising edge", din, p_din);
            if (!sync_n && !sclk && p_sclk) begin
                chk(run == HALF, "R4 high phase", run, HALF);
                sh = {sh[14:0], din};
                nfall++;
            end
            if (!sync_n && sclk && !p_sclk) begin
                if (BYTES && nfall == 8)
                    chk(run == 2*HALF + GAP, "R7 byte gap low time", run, 2*HALF + GAP);
                else
                    chk(run == HALF, "R4 low phase", run, HALF);
            end
            if (done) begin
                chk(!p_done, "R9 done longer than one cycle", 1, 0);
                chk(!busy, "R9 busy during done", busy, 0);
                last_word  = sh;
                last_nfall = nfall;
                frames++;
            end
            if (!sync_n && p_sync) begin
                nfall = 0;
                sh    = '0;
                run   = 1;
            end else if (sclk != p_sclk) run = 1;
            else run++;
            if (sync_n) hi_run++;
            else        hi_run = 0;
        end
        p_sclk = sclk;
        p_sync = sync_n;
        p_din  = din;
        p_done = done;
    end
endmodule

module sim_dacwr_host;
    localparam int CLK_NS = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic [11:0] req_code = '0;
    logic [1:0]  req_mode = '0;

    logic busy0, done0, sclk0, sync0, din0;
    logic busy1, done1, sclk1, sync1, din1;

    int nvec = 0;
    int nbad = 0;

    always #(CLK_NS/2) clk = ~clk;

    dacwr_host #(
        .HALF_CYC(2), .SYNC_HI_CYC(3), .BYTE_MODE(1'b0), .BYTE_GAP_CYC(2),
        .MIRROR(1'b0), .IDLE_LOW(1'b0)
    ) u0 (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_code(req_code),
        .req_mode(req_mode), .busy(busy0), .done(done0), .sclk(sclk0),
        .sync_n(sync0), .din(din0)
    );

    dacwr_host #(
        .HALF_CYC(3), .SYNC_HI_CYC(5), .BYTE_MODE(1'b1), .BYTE_GAP_CYC(2),
        .MIRROR(1'b1), .IDLE_LOW(1'b1)
    ) u1 (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_code(req_code),
        .req_mode(req_mode), .busy(busy1), .done(done1), .sclk(sclk1),
        .sync_n(sync1), .din(din1)
    );

    sim_dacwr_mon #(.HALF(2), .SHI(3), .BYTES(1'b0), .GAP(2)) m0 (
        .clk(clk), .rst(rst), .sclk(sclk0), .sync_n(sync0), .din(din0),
        .busy(busy0), .done(done0)
    );

    sim_dacwr_mon #(.HALF(3), .SHI(5), .BYTES(1'b1), .GAP(2)) m1 (
        .clk(clk), .rst(rst), .sclk(sclk1), .sync_n(sync1), .din(din1),
        .busy(busy1), .done(done1)
    );

    task automatic check(input bit ok, input string tag, input int act, input int expv);
        nvec++;
        if (!ok) begin
            nbad++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, expv);
        end
    endtask

    task automatic report;
        $display("== %0d vectors applied, %0d miscompares ==",
                 nvec + m0.checks + m1.checks, nbad + m0.fails + m1.fails);
    endtask

    task automatic send(input logic [11:0] c, input logic [1:0] m, input bit poke);
        int          f0;
        int          f1;
        logic [15:0] expw;
        f0   = m0.frames;
        f1   = m1.frames;
        expw = {2'b00, m, c};
        @(negedge clk);
        req_valid = 1'b1;
        req_code  = c;
        req_mode  = m;
        @(negedge clk);
        req_valid = 1'b0;
        check(busy0 && busy1, "R9 busy after request", {busy0, busy1}, 2'b11);
        if (poke) begin
            repeat (5) @(negedge clk);
            req_valid = 1'b1;
            req_code  = ~c;
            req_mode  = ~m;
            @(negedge clk);
            req_valid = 1'b0;
        end
        while (m0.frames == f0 || m1.frames == f1) @(negedge clk);
        check(m0.last_word == expw, "R2 wire word (msb storage)", m0.last_word, expw);
        check(m1.last_word == expw, "R2/R10 wire word (mirrored bytes)", m1.last_word, expw);
        check(m0.last_nfall == 16 && m1.last_nfall == 16, "R6 falling edges per frame",
              m0.last_nfall + m1.last_nfall, 32);
        check(sync0 == 1'b1, "R8 select released (IDLE_LOW=0)", sync0, 1);
        check(sync1 == 1'b0, "R8 select idles low (IDLE_LOW=1)", sync1, 0);
        check(!sclk0 && !sclk1, "R6 sclk low after frame", {sclk0, sclk1}, 0);
        if (poke) begin
            repeat (60) @(negedge clk);
            check(m0.frames == f0 + 1 && m1.frames == f1 + 1, "R9 request while busy ignored",
                  m0.frames + m1.frames, f0 + f1 + 2);
            check(!busy0 && !busy1, "R9 no frame started by ignored request",
                  {busy0, busy1}, 0);
            check(sync1 == 1'b0, "R9 idle-low select untouched by ignored request", sync1, 0);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        nbad++;
        nvec++;
        $display("FAIL R9 watchdog: actual=hung expected=frame completion");
        report();
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check(sync0 && sync1 && !sclk0 && !sclk1 && !din0 && !din1 &&
              !busy0 && !busy1 && !done0 && !done1,
              "R1 outputs during reset",
              {sync0, sync1, sclk0, sclk1, din0, din1, busy0, busy1, done0, done1},
              10'b11_0000_0000);
        rst = 1'b0;
        repeat (4) @(negedge clk);
        check(sync0 && sync1 && !sclk0 && !sclk1 && !din0 && !din1 &&
              !busy0 && !busy1 && !done0 && !done1,
              "R1 outputs after reset",
              {sync0, sync1, sclk0, sclk1, din0, din1, busy0, busy1, done0, done1},
              10'b11_0000_0000);

        for (int md = 0; md < 4; md++) begin
            send(12'h000, 2'(md), 1'b0);
            send(12'hFFF, 2'(md), 1'b0);
            send(12'hAAA, 2'(md), 1'b0);
            send(12'h555, 2'(md), 1'b0);
            for (int k = 0; k < 12; k++) send(12'(1 << k), 2'(md), 1'b0);
        end

        // requests presented while a frame is in flight (R9)
        send(12'h3C5, 2'b01, 1'b1);
        send(12'hC3A, 2'b10, 1'b1);

        repeat (5) @(negedge clk);
        report();
        $finish;
    end
endmodule